// File: doc/BRIEF.md
# Cascaded 24-Hour Minute/Hour Counter

This block keeps time of day as hours and minutes. It has two modulo counters in a chain. The first stage holds minutes, from 0 to 59. The second stage holds hours, from 0 to 23. A single count-enable input moves the minutes stage forward by one on each enabled clock edge. The hours stage moves only on the edge where the minutes stage wraps. A single synchronous clear puts both stages back to zero. Setting the time in any other way is not supported.

Each stage drives a top-of-range flag. The flag is high when the stage sits at its last value and the enable reaching that stage is high. The minutes flag is the enable of the hours stage. The hours flag marks the 23:59 to 00:00 rollover, so another stage can be chained after this block. The moduli are parameters, and the output widths follow from them.

Top module: `hhmm_counter`

## Requirements
- R1: While rst_ni is low, min_o and hr_o are 0, and they stay 0 after reset is released until an enabled edge.
- R2: clr_i high at a rising clock edge makes min_o and hr_o both 0 after that edge, whatever ce_i is.
- R3: With clr_i and ce_i both low at an edge, min_o and hr_o keep their values.
- R4: With clr_i low and ce_i high at an edge, min_o below 59 becomes min_o+1.
- R5: With clr_i low and ce_i high at an edge, min_o equal to 59 becomes 0.
- R6: hr_o changes at an edge only on a clear, or when min_o is 59 with ce_i high. In the second case it becomes hr_o+1 when hr_o is below 23.
- R7: At 23:59 with ce_i high and clr_i low, the next value is 00:00.
- R8: min_max_o is high exactly when ce_i is high and min_o is 59, in the same cycle.
- R9: hr_max_o is high exactly when min_max_o is high and hr_o is 23, in the same cycle.
- R10: min_o never exceeds 59 and hr_o never exceeds 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both stages; wins over ce_i |
| ce_i | input | 1 | Count enable for the chain |
| min_o | output | MIN_W (6) | Minutes count, binary |
| hr_o | output | HR_W (5) | Hours count, binary |
| min_max_o | output | 1 | Minutes at 59 with enable high (the hours enable) |
| hr_max_o | output | 1 | Whole-day rollover flag, for chaining further |

## Verification
The bench uses the default moduli of 60 and 24. With these values the outputs are 6 and 5 bits wide. One enabled run of 1440 ticks then covers every minute wrap and every hour wrap of a day, and it ends back at 00:00. The hour rollover is checked 24 times and the full-day flag exactly once. Directed cases cover these points:
- Holding at 23:59 with the enable low.
- A clear during a count, which must win over the enable.
- An asynchronous reset in the middle of a count.

// File: rtl/hhmm_pkg.sv
package hhmm_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_WRAP = 2'd2,
    STEP_CLR  = 2'd3
  } step_e;

  function automatic int unsigned cnt_width(input int unsigned modulus);
    return (modulus < 2) ? 1 : $clog2(modulus);
  endfunction

endpackage

// File: rtl/mod_counter.sv
module mod_counter
  import hhmm_pkg::*;
#(
  parameter int unsigned MOD = 60,
  localparam int unsigned W  = cnt_width(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);

  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;
  step_e        step;

  assign at_top = (cnt_q == TOP);

  always_comb begin
    if (clr_i)            step = STEP_CLR;
    else if (!en_i)       step = STEP_HOLD;
    else if (at_top)      step = STEP_WRAP;
    else                  step = STEP_INC;
  end

  always_comb begin
    unique case (step)
      STEP_INC:  cnt_d = cnt_q + 1'b1;
      STEP_WRAP,
      STEP_CLR:  cnt_d = '0;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  // flag is qualified by the incoming enable so it can feed the next stage directly
  assign max_o = en_i & at_top;

endmodule

// File: rtl/hhmm_counter.sv
module hhmm_counter
  import hhmm_pkg::*;
#(
  parameter int unsigned MIN_MOD = 60,
  parameter int unsigned HR_MOD  = 24,
  localparam int unsigned MIN_W  = cnt_width(MIN_MOD),
  localparam int unsigned HR_W   = cnt_width(HR_MOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ce_i,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o,
  output logic             min_max_o,
  output logic             hr_max_o
);

  logic min_carry;
  logic hr_carry;

  mod_counter #(.MOD(MIN_MOD)) u_min (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (ce_i),
    .cnt_o  (min_o),
    .max_o  (min_carry)
  );

  mod_counter #(.MOD(HR_MOD)) u_hr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (min_carry),
    .cnt_o  (hr_o),
    .max_o  (hr_carry)
  );

  assign min_max_o = min_carry;
  assign hr_max_o  = hr_carry;

endmodule

// File: rtl/hhmm_counter_chk.sv
module hhmm_counter_chk
  import hhmm_pkg::*;
#(
  parameter int unsigned MIN_MOD = 60,
  parameter int unsigned HR_MOD  = 24,
  localparam int unsigned MIN_W  = cnt_width(MIN_MOD),
  localparam int unsigned HR_W   = cnt_width(HR_MOD)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             ce_i,
  input logic [MIN_W-1:0] min_o,
  input logic [HR_W-1:0]  hr_o,
  input logic             min_max_o,
  input logic             hr_max_o
);

  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(MIN_MOD - 1);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(HR_MOD - 1);

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (min_o == '0) && (hr_o == '0));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ce_i) |=> $stable(min_o) && $stable(hr_o));

  assert_min_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ce_i && min_o != MIN_TOP) |=> min_o == $past(min_o) + 1'b1);

  assert_min_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ce_i && min_o == MIN_TOP) |=> min_o == '0);

  assert_hr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(ce_i && min_o == MIN_TOP)) |=> $stable(hr_o));

  assert_hr_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ce_i && min_o == MIN_TOP && hr_o != HR_TOP) |=> hr_o == $past(hr_o) + 1'b1);

  assert_day_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ce_i && min_o == MIN_TOP && hr_o == HR_TOP) |=> (min_o == '0) && (hr_o == '0));

  assert_min_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_max_o |-> ce_i && (min_o == MIN_TOP));

  assert_hr_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_max_o |-> min_max_o && (hr_o == HR_TOP));

  assert_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_o <= MIN_TOP) && (hr_o <= HR_TOP));

endmodule

bind hhmm_counter hhmm_counter_chk #(.MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .ce_i      (ce_i),
  .min_o     (min_o),
  .hr_o      (hr_o),
  .min_max_o (min_max_o),
  .hr_max_o  (hr_max_o)
);

// File: tb/tb_hhmm_counter.sv
`timescale 1ns/1ps
module tb_hhmm_counter;

  localparam int MIN_W = 6;
  localparam int HR_W  = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic             ce_i = 1'b0;
  logic [MIN_W-1:0] min_o;
  logic [HR_W-1:0]  hr_o;
  logic             min_max_o;
  logic             hr_max_o;

  int total = 0;
  int bad = 0;
  int ref_min = 0;
  int ref_hr = 0;
  int day_flags = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hhmm_counter dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .ce_i      (ce_i),
    .min_o     (min_o),
    .hr_o      (hr_o),
    .min_max_o (min_max_o),
    .hr_max_o  (hr_max_o)
  );

  typedef struct packed {
    logic       clr;
    logic       ce;
    logic [7:0] reps;
    logic [7:0] emin;
    logic [7:0] ehr;
  } vec_t;

  // rows: R4 count, R3 hold, R2 clear over enable, R4 to 59, R5/R6 wrap, R3 hold, R6 hour, R2 clear
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd5,  8'd5,  8'd0},
    '{1'b0, 1'b0, 8'd3,  8'd5,  8'd0},
    '{1'b1, 1'b1, 8'd1,  8'd0,  8'd0},
    '{1'b0, 1'b1, 8'd59, 8'd59, 8'd0},
    '{1'b0, 1'b1, 8'd1,  8'd0,  8'd1},
    '{1'b0, 1'b0, 8'd10, 8'd0,  8'd1},
    '{1'b0, 1'b1, 8'd60, 8'd0,  8'd2},
    '{1'b1, 1'b0, 8'd1,  8'd0,  8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; checks flags, then counts after the next edge
  task automatic tick(input bit c, input bit e);
    bit emm;
    clr_i = c;
    ce_i  = e;
    #1;
    emm = e && (ref_min == 59);
    chk("R8 min_max_o", int'(min_max_o), int'(emm));
    chk("R9 hr_max_o", int'(hr_max_o), int'(emm && ref_hr == 23));
    if (hr_max_o) day_flags++;
    @(posedge clk);
    if (c) begin
      ref_min = 0; ref_hr = 0;
    end else if (e) begin
      if (ref_min == 59) begin
        ref_min = 0;
        ref_hr  = (ref_hr == 23) ? 0 : ref_hr + 1;
      end else begin
        ref_min = ref_min + 1;
      end
    end
    @(negedge clk);
    chk("R4/R5 min_o", int'(min_o), ref_min);
    chk("R6/R7 hr_o", int'(hr_o), ref_hr);
  endtask

  task automatic go_to(input int h, input int m);
    tick(1'b1, 1'b0);
    for (int i = 0; i < h * 60 + m; i++) tick(1'b0, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 min_o in reset", int'(min_o), 0);
    chk("R1 hr_o in reset", int'(hr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 min_o after release", int'(min_o), 0);
    chk("R1 hr_o after release", int'(hr_o), 0);

    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VECS[v].reps); r++) tick(VECS[v].clr, VECS[v].ce);
      chk($sformatf("R2/R3/R4 row %0d min", v), int'(min_o), int'(VECS[v].emin));
      chk($sformatf("R2/R3/R6 row %0d hr", v), int'(hr_o), int'(VECS[v].ehr));
    end

    // R7: a full day from 00:00 returns to 00:00, day flag once
    day_flags = 0;
    for (int i = 0; i < 1440; i++) begin
      tick(1'b0, 1'b1);
      chk("R10 min range", int'(min_o <= 59), 1);
      chk("R10 hr range", int'(hr_o <= 23), 1);
    end
    chk("R7 day end min", int'(min_o), 0);
    chk("R7 day end hr", int'(hr_o), 0);
    chk("R9 day flag count", day_flags, 1);

    // R3: hold at 23:59 with enable low
    go_to(23, 59);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    chk("R3 hold min at 23:59", int'(min_o), 59);
    chk("R3 hold hr at 23:59", int'(hr_o), 23);
    tick(1'b0, 1'b1);
    chk("R7 wrap min", int'(min_o), 0);
    chk("R7 wrap hr", int'(hr_o), 0);

    // R2: clear wins over enable at 12:59
    go_to(12, 59);
    tick(1'b1, 1'b1);
    chk("R2 clear min", int'(min_o), 0);
    chk("R2 clear hr", int'(hr_o), 0);

    // R1: asynchronous reset mid-count
    go_to(7, 33);
    clr_i = 1'b0; ce_i = 1'b1;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async min", int'(min_o), 0);
    chk("R1 async hr", int'(hr_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    ce_i = 1'b0;
    ref_min = 0; ref_hr = 0;
    @(negedge clk);
    tick(1'b0, 1'b1);
    chk("R4 count after reset", int'(min_o), 1);

    finish_run();
  end

endmodule